// File: doc/BRIEF.md
# Two-Wire Serial Slave Controller

This block is the slave side of an I2C-compatible two-wire bus, and it has no master capability. A CPU programs a 7-bit own address and sets an enable bit. After that the block watches the synchronized SCL and SDA lines for start and stop conditions and takes in the address byte. It compares the address in hardware, and it also accepts the general call address. It acknowledges the address and every received data byte by itself. After each byte it holds SCL low until the CPU accesses the data register. The block drives the bus only through two open-drain enables: a 1 on an enable pulls that line low.

When a start condition is seen, the programmed address is loaded into the shift register as `{own_addr, 0}`. Each incoming address bit is compared with the shift-register MSB before the shift, so the match result is ready when the R/W bit arrives. A status flag marks every serviced event and drives an interrupt when interrupts are enabled. The CPU services a receive byte by reading the data register. It supplies a transmit byte by writing the data register.

The controller is built around the state machine `i2cs_fsm`. Its states and transitions are:

- `ST_IDLE` goes to `ST_ADDR` on a start condition.
- `ST_ADDR` shifts in 8 bits. On the falling edge after the 8th bit it goes to `ST_ADDR_ACK` if the address matches, or to `ST_IGNORE` if it does not.
- `ST_ADDR_ACK` drives SDA low. On the 9th falling edge it goes to `ST_HOLD`.
- `ST_HOLD` stretches SCL. When the CPU accesses the data register it goes to `ST_RX` or `ST_TX`, according to R/W.
- `ST_RX` goes to `ST_RX_ACK` after 8 bits.
- `ST_RX_ACK` goes to `ST_HOLD`.
- `ST_TX` goes to `ST_TX_ACK` after 8 bits.
- `ST_TX_ACK` goes to `ST_HOLD` if the master sends ACK, or to `ST_IGNORE` if it sends NACK.
- A start condition in any state goes to `ST_ADDR`.
- A stop condition, or a cleared enable bit, goes to `ST_IDLE` from any state.

Top module: `i2c_slave_ctl`

## Requirements
- R1: After reset, the control register (select 0) reads 0, the status register (select 1) reads 0, `irq` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: While enable (control bit 0) is 0, the block releases both lines, acknowledges nothing and holds the status flag at 0. Clearing enable while SCL is being stretched releases SCL and clears the flag.
- R3: Address bits are sampled MSB first on rising SCL. A 7-bit address equal to the own address (select 2, bits 6:0) is acknowledged with SDA held low during the 9th clock. SDA is only changed while SCL is low.
- R4: The address 0x00 with R/W=0 is acknowledged as a general call and sets status bit 2. The address 0x00 with R/W=1 is not acknowledged.
- R5: A non-matching address is not acknowledged. The block then ignores all bytes until the next start, with no ACK and no flag.
- R6: Each data byte received after a matched write address is acknowledged and then reads back from the data register (select 3). After an address phase, the data register holds the received address byte.
- R7: The status flag (status bit 0) sets at the end of the ACK clock of a matched address or a received byte. `irq` equals flag AND interrupt-enable (control bit 1).
- R8: When the flag sets, SCL is held low until the CPU reads or writes select 3. That access clears the flag.
- R9: With R/W=1, status bit 1 is 1. The byte written to the data register is sent MSB first, and a master ACK leads to a new flag and a new stretch.
- R10: A master NACK on a transmitted byte sets status bit 3 and releases SDA and SCL. No flag and no stretch follow until the next start.
- R11: A stop returns the block to idle from any state, including in the middle of an address. A repeated start restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as service on select 3) |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 own address, 3 data |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The clock stretch and a CPU write that clears enable can fall in the same cycle. In the bench, the CPU clears the enable bit while the block is holding SCL low after a matched address. The expected result is that disable wins: on the following cycles SCL and SDA are released, the flag reads 0 and `irq` is low. This is judged at the ports, and the release must not wait for any data-register access.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_OWN  = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign start    = scl_s & scl_p & sda_p & ~sda_s;
    assign stop     = scl_s & scl_p & ~sda_p & sda_s;
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-2:0] own_addr,
    input  logic          start,
    input  logic          stop,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          svc,
    input  logic          svc_wr,
    input  logic [DW-1:0] wdata,
    output logic          scl_hold,
    output logic          sda_drive,
    output logic          set_flag,
    output logic          rx_load,
    output logic [DW-1:0] rx_byte,
    output logic          rw_mode,
    output logic          gc_hit,
    output logic          nack_seen
);
    localparam int AW = DW - 1;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DW);
    localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);
    localparam logic [CW-1:0] CNT_ADDR = CW'(AW);

    state_t        st, nxt;
    logic [DW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic          m_own, m_gc, ack_sda;
    logic          addr_hit;

    assign addr_hit = m_own | (m_gc & ~shreg[0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (start) nxt = ST_ADDR;
            ST_ADDR:     if (scl_fall && cnt == CNT_FULL)
                             nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK: if (scl_fall) nxt = ST_HOLD;
            ST_HOLD:     if (svc) nxt = rw_mode ? ST_TX : ST_RX;
            ST_RX:       if (scl_fall && cnt == CNT_FULL) nxt = ST_RX_ACK;
            ST_RX_ACK:   if (scl_fall) nxt = ST_HOLD;
            ST_TX:       if (scl_fall && cnt == CNT_LAST) nxt = ST_TX_ACK;
            ST_TX_ACK:   if (scl_fall) nxt = ack_sda ? ST_IGNORE : ST_HOLD;
            ST_IGNORE:   nxt = ST_IGNORE;
            default:     nxt = ST_IDLE;
        endcase
        if (start) nxt = ST_ADDR;
        if (stop)  nxt = ST_IDLE;
        if (!en)   nxt = ST_IDLE;
    end

    // datapath: shift register, bit counter, address match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            m_own     <= 1'b0;
            m_gc      <= 1'b0;
            ack_sda   <= 1'b1;
            rw_mode   <= 1'b0;
            gc_hit    <= 1'b0;
            nack_seen <= 1'b0;
        end else if (en && start) begin
            shreg <= {own_addr, 1'b0};
            cnt   <= '0;
            m_own <= 1'b1;
            m_gc  <= 1'b1;
        end else if (en) begin
            case (st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        if (cnt < CNT_ADDR) begin
                            if (sda_s != shreg[DW-1]) m_own <= 1'b0;
                            if (sda_s) m_gc <= 1'b0;
                        end
                        shreg <= {shreg[DW-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end
                    if (scl_fall && cnt == CNT_FULL) begin
                        rw_mode   <= shreg[0];
                        gc_hit    <= m_gc & ~shreg[0] & ~m_own;
                        nack_seen <= 1'b0;
                    end
                end
                ST_HOLD: if (svc) begin
                    cnt <= '0;
                    if (rw_mode && svc_wr) shreg <= wdata;
                end
                ST_RX: if (scl_rise) begin
                    shreg <= {shreg[DW-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end
                ST_TX: if (scl_fall) begin
                    shreg <= {shreg[DW-2:0], 1'b1};
                    cnt   <= cnt + 1'b1;
                end
                ST_TX_ACK: begin
                    if (scl_rise) ack_sda <= sda_s;
                    if (scl_fall && ack_sda) nack_seen <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        scl_hold  = 1'b0;
        sda_drive = 1'b0;
        set_flag  = 1'b0;
        rx_load   = 1'b0;
        unique case (st)
            ST_ADDR_ACK: begin
                sda_drive = 1'b1;
                set_flag  = scl_fall & en;
                rx_load   = scl_fall & en;
            end
            ST_RX_ACK: begin
                sda_drive = 1'b1;
                set_flag  = scl_fall & en;
                rx_load   = scl_fall & en;
            end
            ST_HOLD:   scl_hold  = 1'b1;
            ST_TX:     sda_drive = ~shreg[DW-1];
            ST_TX_ACK: set_flag  = scl_fall & ~ack_sda & en;
            default: ;
        endcase
    end

    assign rx_byte = shreg;
endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
    import i2cs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe
);
    logic [1:0]    line_s;
    logic          scl_s, sda_s;
    logic          start, stop, scl_rise, scl_fall;
    logic          ctl_en, ctl_ie, flag_q;
    logic [DW-2:0] own_q;
    logic [DW-1:0] data_q;
    logic          svc, svc_wr;
    logic          set_flag, rx_load, rw_mode, gc_hit, nack_seen;
    logic [DW-1:0] rx_byte;
    logic [DW-1:0] stat;

    i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}), .dout(line_s)
    );
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    i2cs_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    assign svc_wr = ctl_en & reg_wr & (reg_sel == SEL_DATA);
    assign svc    = svc_wr | (ctl_en & reg_rd & (reg_sel == SEL_DATA));

    i2cs_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .own_addr(own_q),
        .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .svc(svc), .svc_wr(svc_wr), .wdata(reg_wdata),
        .scl_hold(scl_oe), .sda_drive(sda_oe), .set_flag(set_flag),
        .rx_load(rx_load), .rx_byte(rx_byte), .rw_mode(rw_mode),
        .gc_hit(gc_hit), .nack_seen(nack_seen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            ctl_ie <= 1'b0;
            own_q  <= '0;
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_CTRL) begin
                ctl_en <= reg_wdata[0];
                ctl_ie <= reg_wdata[1];
            end
            if (reg_wr && reg_sel == SEL_OWN) own_q <= reg_wdata[DW-2:0];
            if (rx_load) data_q <= rx_byte;
            else if (reg_wr && reg_sel == SEL_DATA) data_q <= reg_wdata;
            if (!ctl_en)       flag_q <= 1'b0;
            else if (set_flag) flag_q <= 1'b1;
            else if (svc)      flag_q <= 1'b0;
        end
    end

    always_comb begin
        stat    = '0;
        stat[0] = flag_q;
        stat[1] = rw_mode;
        stat[2] = gc_hit;
        stat[3] = nack_seen;
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = DW'({ctl_ie, ctl_en});
            SEL_STAT: reg_rdata = stat;
            SEL_OWN:  reg_rdata = DW'(own_q);
            default:  reg_rdata = data_q;
        endcase
    end

    assign irq = flag_q & ctl_ie;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic flag,
    input logic svc,
    input logic scl_oe,
    input logic sda_oe,
    input logic scl_s,
    input logic nack
);
    // R2: lines released once enable has been low for a cycle
    a_r2_off_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (!scl_oe && !sda_oe));

    // R8: a new flag always coincides with a clock stretch
    a_r8_flag_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> scl_oe);

    // R8: the stretch persists until a data access
    a_r8_hold_until_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !svc && en) |=> scl_oe);

    // R3: SDA is only pulled low while synchronized SCL is low
    a_r3_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R10: a NACK leaves both lines released
    a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_slave_ctl i2cs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .flag(flag_q), .svc(svc),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_s(scl_s), .nack(nack_seen)
);

// File: tb/test_i2c_slave_ctl.sv
`timescale 1ns/1ps
module test_i2c_slave_ctl;
    localparam int T = 20;
    localparam logic [6:0] OWN = 7'h52;
    // {address byte, data byte, ack expected}
    localparam logic [16:0] VEC [7] = '{
        {8'hA4, 8'h3C, 1'b1},
        {8'h00, 8'hC3, 1'b1},
        {8'hA6, 8'h55, 1'b0},
        {8'h01, 8'h77, 1'b0},
        {8'h24, 8'h99, 1'b0},
        {8'hA4, 8'h00, 1'b1},
        {8'hA4, 8'hFF, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic scl_w, sda_w;
    int total = 0, bad = 0;
    bit reported = 0;

    always #4 clk = ~clk;
    assign scl_w = ~(m_scl_lo | scl_oe);
    assign sda_w = ~(m_sda_lo | sda_oe);

    i2c_slave_ctl i_i2c_slave_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rwrite(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rread(logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic m_bit(logic b, output logic r);
        m_sda_lo = ~b;
        wt(T);
        m_scl_lo = 1'b0;
        while (!scl_w) @(negedge clk);
        wt(T);
        r = sda_w;
        m_scl_lo = 1'b1;
        wt(T);
    endtask

    task automatic m_start();
        m_sda_lo = 1'b0;
        wt(T);
        m_scl_lo = 1'b0;
        while (!scl_w) @(negedge clk);
        wt(T);
        m_sda_lo = 1'b1;
        wt(T);
        m_scl_lo = 1'b1;
        wt(T);
    endtask

    task automatic m_stop();
        m_sda_lo = 1'b1;
        wt(T);
        m_scl_lo = 1'b0;
        while (!scl_w) @(negedge clk);
        wt(T);
        m_sda_lo = 1'b0;
        wt(T);
    endtask

    task automatic m_wbyte(logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        ack = ~r;
        wt(4);
    endtask

    task automatic m_rbyte(logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            b[i] = r;
        end
        m_bit(~give_ack, r);
        wt(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [7:0] d;
        logic ack;
        wt(3);
        // R1: reset state
        chk("R1 ctrl", {6'd0, irq, scl_oe | sda_oe}, 8'h00);
        rread(2'd0, d); chk("R1 ctrl reg", d, 8'h00);
        rread(2'd1, d); chk("R1 status reg", d, 8'h00);
        rst_n = 1'b1;
        wt(3);
        rread(2'd0, d); chk("R1 ctrl after release", d, 8'h00);
        chk("R1 lines", {6'd0, scl_oe, sda_oe}, 8'h00);

        rwrite(2'd2, {1'b0, OWN});
        // R2: disabled block does not acknowledge
        m_start(); m_wbyte(8'hA4, ack);
        chk("R2 no ack while disabled", {7'd0, ack}, 8'h00);
        rread(2'd1, d); chk("R2 flag off while disabled", d & 8'h01, 8'h00);
        m_stop(); wt(4);

        rwrite(2'd0, 8'h03);
        // vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 7; v++) begin
            logic [7:0] a, dat;
            logic ex;
            {a, dat, ex} = VEC[v];
            m_start(); m_wbyte(a, ack);
            chk("R3 R4 R5 address ack", {7'd0, ack}, {7'd0, ex});
            if (ex) begin
                rread(2'd1, d);
                chk("R7 R4 status after address", d & 8'h07,
                    {5'd0, a[7:1] == 7'd0, 1'b0, 1'b1});
                chk("R7 irq", {7'd0, irq}, 8'h01);
                wt(40);
                chk("R8 stretch held", {7'd0, scl_oe}, 8'h01);
                rread(2'd3, d); chk("R6 address in data reg", d, a);
                wt(2);
                chk("R8 release after read", {7'd0, scl_oe}, 8'h00);
                rread(2'd1, d); chk("R8 flag cleared", d & 8'h01, 8'h00);
                m_wbyte(dat, ack);
                chk("R6 data ack", {7'd0, ack}, 8'h01);
                rread(2'd1, d); chk("R7 flag after data", d & 8'h01, 8'h01);
                rread(2'd3, d); chk("R6 data value", d, dat);
            end else begin
                rread(2'd1, d); chk("R5 no flag", d & 8'h01, 8'h00);
                m_wbyte(dat, ack);
                chk("R5 data ignored", {7'd0, ack}, 8'h00);
                chk("R5 no stretch", {6'd0, scl_oe, irq}, 8'h00);
            end
            m_stop(); wt(4);
        end

        // R9 R10: slave transmit with ACK then NACK
        m_start(); m_wbyte(8'hA5, ack);
        chk("R9 read address ack", {7'd0, ack}, 8'h01);
        rread(2'd1, d); chk("R9 status rw and flag", d & 8'h0B, 8'h03);
        rwrite(2'd3, 8'h96);
        wt(2); chk("R8 release after write", {7'd0, scl_oe}, 8'h00);
        m_rbyte(1'b1, d); chk("R9 first tx byte", d, 8'h96);
        rread(2'd1, d); chk("R9 flag after master ack", d & 8'h01, 8'h01);
        chk("R9 stretch after ack", {7'd0, scl_oe}, 8'h01);
        rwrite(2'd3, 8'h5A);
        m_rbyte(1'b0, d); chk("R9 second tx byte", d, 8'h5A);
        wt(40);
        rread(2'd1, d); chk("R10 nack status, no flag", d & 8'h09, 8'h08);
        chk("R10 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        m_stop(); wt(4);

        // R11: stop in mid-address, then a clean transfer
        m_start(); m_bit(1'b1, ack); m_bit(1'b0, ack); m_bit(1'b1, ack);
        m_stop(); wt(4);
        chk("R11 idle after stop", {6'd0, scl_oe, sda_oe}, 8'h00);
        m_start(); m_wbyte(8'hA4, ack);
        chk("R11 ack after aborted address", {7'd0, ack}, 8'h01);
        rread(2'd3, d);
        m_wbyte(8'h11, ack);
        chk("R6 byte before repeated start", {7'd0, ack}, 8'h01);
        rread(2'd3, d);
        // R11: repeated start switches to transmit
        m_start(); m_wbyte(8'hA5, ack);
        chk("R11 repeated start ack", {7'd0, ack}, 8'h01);
        rread(2'd1, d); chk("R11 rw after repeated start", d & 8'h03, 8'h03);
        rwrite(2'd3, 8'hC1);
        m_rbyte(1'b0, d); chk("R11 tx after repeated start", d, 8'hC1);
        m_stop(); wt(4);

        // R2: disable during stretch wins over the hold
        m_start(); m_wbyte(8'hA4, ack);
        chk("R2 setup ack", {7'd0, scl_oe, ack}, 8'h03);
        rwrite(2'd0, 8'h02);
        wt(2);
        chk("R2 disable releases", {5'd0, irq, scl_oe, sda_oe}, 8'h00);
        rread(2'd1, d); chk("R2 flag cleared by disable", d & 8'h01, 8'h00);
        m_stop(); wt(4);

        report();
    end
endmodule